// File: doc/BRIEF.md
# Multi-Window Exposure Integrator

This block measures scene brightness for an auto-exposure loop. It takes raw 10-bit sensor samples, as they leave the analog-to-digital converter and before any colour processing, along with a pixel-valid qualifier and single-cycle horizontal and vertical sync strobes. From these strobes it keeps its own pixel column and line counters. Six rectangular measurement areas can be placed anywhere in the image through a small register file. For each area, the block adds up every sample that falls inside it during one field.

At each vertical sync strobe the six running sums are copied into holding registers and the accumulators restart from zero. An external exposure controller reads the held sums by index and uses them to steer the shutter time or the iris. Reads are not allowed during the first line after the vertical strobe, and a read-blocked flag covers that interval. Two window-pulse outputs show, pixel by pixel, whether the current sample lies inside any area enabled in each pulse's own selection mask. Typical uses are driving an overlay or an external detector.

Top module: `ae_window_integrator`

## Requirements
- R1: After reset, every held sum reads 0, `rd_block` is 0 and both `win_pulse` bits are 0. All bounds and masks are 0.
- R2: The column coordinate equals the number of accepted samples since the last sync strobe of either kind. The line coordinate equals the number of horizontal strobes since the last vertical strobe. A sample is accepted only when `pix_valid` is 1 and neither strobe is high in that cycle; a sample presented together with a strobe is dropped.
- R3: Area w contains pixel (x, y) when h_lo ≤ x ≤ h_hi and v_lo ≤ y ≤ v_hi, with both bounds inclusive. An area whose start bound exceeds its end bound contains nothing.
- R4: Each area adds every accepted sample it contains to its own 28-bit accumulator. Where areas overlap, one sample is added to every area that contains it.
- R5: In a cycle with `vsync` high, each accumulator's total is copied to that area's holding register and the accumulator is cleared. The holding registers do not change at any other time.
- R6: `rd_data` shows the holding register selected by `rd_sel` (0 to 5) in the same cycle. Selection values 6 and 7 read 0.
- R7: `rd_block` rises in the cycle after a `vsync` strobe. It falls in the cycle after the next `hsync` strobe, which ends the first line.
- R8: `win_pulse[k]` is high exactly in cycles with an accepted sample that lies inside at least one area enabled in mask k. Bit i of a mask enables area i.
- R9: Register map for `cfg_addr`: address 4·w + f writes bound f of area w, where f = 0 is h_lo, 1 is h_hi, 2 is v_lo and 3 is v_hi. Address 24 writes mask 0 and address 25 writes mask 1, each from the low 6 bits of `cfg_wdata`. A write takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid | input | 1 | Sample qualifier |
| hsync | input | 1 | Line-start strobe |
| vsync | input | 1 | Field-start strobe |
| pix_data | input | 10 | Raw sensor sample |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 10 | Register write data |
| rd_sel | input | 3 | Held-sum selector |
| rd_data | output | 28 | Selected held sum |
| rd_block | output | 1 | Readback-forbidden flag |
| win_pulse | output | 2 | Per-mask window indicators |

## Verification
Two events can coincide in the same cycle. A sync strobe can arrive together with an asserted `pix_valid`: on the field boundary, the vertical strobe copies the totals while a sample is presented, and on a line boundary, a horizontal strobe carries a sample. In some fields the bench deliberately drives a full-scale sample with every strobe. Its arithmetic model leaves those samples out, so a wrong drop rule shows up as a miscompare in the held sums and as a spurious window pulse. Overlapping areas are judged in the same way, since one sample must raise several independent totals.

// File: rtl/ae_pkg.sv
package ae_pkg;
  typedef enum logic [1:0] {
    BND_H_LO = 2'd0,
    BND_H_HI = 2'd1,
    BND_V_LO = 2'd2,
    BND_V_HI = 2'd3
  } bound_sel_e;

  // inclusive span membership; lo > hi yields an empty span
  function automatic logic span_hit(input int unsigned pos,
                                    input int unsigned lo,
                                    input int unsigned hi);
    return (pos >= lo) && (pos <= hi);
  endfunction
endpackage

// File: rtl/ae_pos_counter.sv
module ae_pos_counter #(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  input  logic               hsync,
  input  logic               vsync,
  output logic [COORD_W-1:0] col,
  output logic [COORD_W-1:0] row,
  output logic               sample_take,
  output logic               rd_block
);
  localparam logic [COORD_W-1:0] CMAX = '1;

  assign sample_take = pix_valid && !hsync && !vsync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col      <= '0;
      row      <= '0;
      rd_block <= 1'b0;
    end else begin
      if (hsync || vsync)
        col <= '0;
      else if (sample_take && col != CMAX)
        col <= col + 1'b1;

      if (vsync)
        row <= '0;
      else if (hsync && row != CMAX)
        row <= row + 1'b1;

      if (vsync)
        rd_block <= 1'b1;
      else if (hsync)
        rd_block <= 1'b0;
    end
  end
endmodule

// File: rtl/ae_window_regs.sv
module ae_window_regs #(
  parameter int NUM_WIN = 6,
  parameter int COORD_W = 10,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [COORD_W-1:0] cfg_wdata,
  output logic [COORD_W-1:0] h_lo [NUM_WIN],
  output logic [COORD_W-1:0] h_hi [NUM_WIN],
  output logic [COORD_W-1:0] v_lo [NUM_WIN],
  output logic [COORD_W-1:0] v_hi [NUM_WIN],
  output logic [NUM_WIN-1:0] mask_a,
  output logic [NUM_WIN-1:0] mask_b
);
  import ae_pkg::*;
  localparam int MASK_BASE = NUM_WIN * 4;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        h_lo[w] <= '0;
        h_hi[w] <= '0;
        v_lo[w] <= '0;
        v_hi[w] <= '0;
      end else if (cfg_we) begin
        if (hit(cfg_addr, w*4 + int'(BND_H_LO))) h_lo[w] <= cfg_wdata;
        if (hit(cfg_addr, w*4 + int'(BND_H_HI))) h_hi[w] <= cfg_wdata;
        if (hit(cfg_addr, w*4 + int'(BND_V_LO))) v_lo[w] <= cfg_wdata;
        if (hit(cfg_addr, w*4 + int'(BND_V_HI))) v_hi[w] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_a <= '0;
      mask_b <= '0;
    end else if (cfg_we) begin
      if (hit(cfg_addr, MASK_BASE))     mask_a <= cfg_wdata[NUM_WIN-1:0];
      if (hit(cfg_addr, MASK_BASE + 1)) mask_b <= cfg_wdata[NUM_WIN-1:0];
    end
  end
endmodule

// File: rtl/ae_accum.sv
module ae_accum #(
  parameter int DATA_W = 10,
  parameter int ACC_W  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_end,
  input  logic              add_en,
  input  logic [DATA_W-1:0] sample,
  output logic [ACC_W-1:0]  sum,
  output logic [ACC_W-1:0]  held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum  <= '0;
      held <= '0;
    end else if (field_end) begin
      held <= sum;
      sum  <= '0;
    end else if (add_en) begin
      sum <= sum + ACC_W'(sample);
    end
  end
endmodule

// File: rtl/ae_window_integrator.sv
module ae_window_integrator #(
  parameter int NUM_WIN = 6,
  parameter int COORD_W = 10,
  parameter int DATA_W  = 10,
  parameter int ACC_W   = 28,
  parameter int ADDR_W  = $clog2(NUM_WIN * 4 + 2),
  parameter int SEL_W   = $clog2(NUM_WIN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  input  logic               hsync,
  input  logic               vsync,
  input  logic [DATA_W-1:0]  pix_data,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [COORD_W-1:0] cfg_wdata,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [ACC_W-1:0]   rd_data,
  output logic               rd_block,
  output logic [1:0]         win_pulse
);
  import ae_pkg::*;

  logic [COORD_W-1:0] col, row;
  logic               sample_take;
  logic               field_end;
  logic [COORD_W-1:0] h_lo [NUM_WIN];
  logic [COORD_W-1:0] h_hi [NUM_WIN];
  logic [COORD_W-1:0] v_lo [NUM_WIN];
  logic [COORD_W-1:0] v_hi [NUM_WIN];
  logic [NUM_WIN-1:0] mask_a, mask_b;
  logic [NUM_WIN-1:0] in_win;
  logic [ACC_W-1:0]   acc_sum  [NUM_WIN];
  logic [ACC_W-1:0]   acc_held [NUM_WIN];
  logic [NUM_WIN*ACC_W-1:0] acc_flat;

  assign field_end = vsync;

  ae_pos_counter #(.COORD_W(COORD_W)) u_pos (
    .clk, .rst_n, .pix_valid, .hsync, .vsync,
    .col, .row, .sample_take, .rd_block
  );

  ae_window_regs #(.NUM_WIN(NUM_WIN), .COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .h_lo, .h_hi, .v_lo, .v_hi, .mask_a, .mask_b
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_acc
    assign in_win[w] = span_hit(32'(col), 32'(h_lo[w]), 32'(h_hi[w])) &&
                       span_hit(32'(row), 32'(v_lo[w]), 32'(v_hi[w]));

    ae_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
      .clk, .rst_n,
      .field_end,
      .add_en (sample_take && in_win[w]),
      .sample (pix_data),
      .sum    (acc_sum[w]),
      .held   (acc_held[w])
    );

    assign acc_flat[w*ACC_W +: ACC_W] = acc_sum[w];
  end

  assign win_pulse[0] = sample_take && |(mask_a & in_win);
  assign win_pulse[1] = sample_take && |(mask_b & in_win);

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_WIN; i++)
      if (rd_sel == SEL_W'(i)) rd_data = acc_held[i];
  end
endmodule

// File: rtl/ae_integ_chk.sv
module ae_integ_chk #(
  parameter int NUM_WIN = 6,
  parameter int ACC_W   = 28,
  parameter int SEL_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     pix_valid,
  input logic                     hsync,
  input logic                     vsync,
  input logic [SEL_W-1:0]         rd_sel,
  input logic [ACC_W-1:0]         rd_data,
  input logic                     rd_block,
  input logic [1:0]               win_pulse,
  input logic [NUM_WIN*ACC_W-1:0] acc_flat
);
  // R7
  rd_block_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> rd_block);

  // R7
  rd_block_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && !vsync) |=> !rd_block);

  // R5
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> (!$stable(rd_sel) || $stable(rd_data)));

  // R5
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (acc_flat == '0));

  // R8
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid || hsync || vsync) |-> (win_pulse == 2'b00));

  // R6
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel >= SEL_W'(NUM_WIN)) |-> (rd_data == '0));
endmodule

bind ae_window_integrator ae_integ_chk #(
  .NUM_WIN(NUM_WIN), .ACC_W(ACC_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .hsync(hsync),
  .vsync(vsync), .rd_sel(rd_sel), .rd_data(rd_data), .rd_block(rd_block),
  .win_pulse(win_pulse), .acc_flat(acc_flat)
);

// File: tb/ae_window_integrator_bench.sv
module ae_window_integrator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 40;
  localparam int FH = 24;
  localparam int NW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0, hsync = 1'b0, vsync = 1'b0;
  logic [9:0] pix_data = '0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [9:0] cfg_wdata = '0;
  logic [2:0] rd_sel = '0;
  logic [27:0] rd_data;
  logic rd_block;
  logic [1:0] win_pulse;

  ae_window_integrator u_ae_window_integrator (
    .clk, .rst_n, .pix_valid, .hsync, .vsync, .pix_data,
    .cfg_we, .cfg_addr, .cfg_wdata, .rd_sel, .rd_data, .rd_block, .win_pulse
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int hl[NW], hh[NW], vl[NW], vh[NW];
  int ma = 0, mb = 0;
  longint prev_sum[NW];
  longint cur_sum[NW];
  bit done = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pattern(int x, int y, int seed);
    if (seed == 2) return 1023;
    return (x*13 + y*7 + seed*29 + x*y) % 1024;
  endfunction

  function automatic bit covers(int w, int x, int y);
    return (x >= hl[w]) && (x <= hh[w]) && (y >= vl[w]) && (y <= vh[w]);
  endfunction

  task automatic write_cfg(int addr, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = 10'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R9: address 4*w+f, f: 0 h_lo, 1 h_hi, 2 v_lo, 3 v_hi
  task automatic set_win(int w, int a, int b, int c, int d);
    hl[w] = a; hh[w] = b; vl[w] = c; vh[w] = d;
    write_cfg(w*4 + 0, a);
    write_cfg(w*4 + 1, b);
    write_cfg(w*4 + 2, c);
    write_cfg(w*4 + 3, d);
  endtask

  // R9: masks at 24 and 25
  task automatic set_masks(int a, int b);
    ma = a; mb = b;
    write_cfg(24, a);
    write_cfg(25, b);
  endtask

  task automatic read_all(string tag);
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      #1;
      // R5 R6: held sums of previous field, 6 and 7 read zero
      chk(tag, rd_data, (s < NW) ? prev_sum[s] : 0);
    end
  endtask

  task automatic pulse_chk(bit exp0, bit exp1);
    #1;
    // R8
    chk("R8 pulse0", win_pulse[0], exp0);
    chk("R8 pulse1", win_pulse[1], exp1);
  endtask

  task automatic run_field(int seed, bit noise);
    for (int w = 0; w < NW; w++) cur_sum[w] = 0;
    @(negedge clk);
    vsync = 1'b1; pix_valid = noise; pix_data = 10'd1023;
    pulse_chk(0, 0);                       // R2: strobe drops sample
    @(negedge clk);
    vsync = 1'b0;
    for (int y = 0; y < FH; y++) begin
      if (y > 0) begin
        hsync = 1'b1; pix_valid = noise; pix_data = 10'd1023;
        pulse_chk(0, 0);                   // R2
        @(negedge clk);
        hsync = 1'b0; pix_valid = 1'b0;
        #1;
        if (y == 1) begin
          chk("R7 block falls", rd_block, 0);
          read_all("R5 R6 readback");
        end
        if (y == FH-1) read_all("R5 hold stable");
      end
      for (int x = 0; x < FW; x++) begin
        bit e0, e1;
        if (x % 7 == 3) begin
          pix_valid = 1'b0; pix_data = 10'd1023;
          pulse_chk(0, 0);
          @(negedge clk);
        end
        pix_valid = 1'b1; pix_data = 10'(pattern(x, y, seed));
        e0 = 0; e1 = 0;
        for (int w = 0; w < NW; w++) begin
          if (covers(w, x, y)) begin
            cur_sum[w] += pattern(x, y, seed);   // R3 R4
            if (ma[w]) e0 = 1;
            if (mb[w]) e1 = 1;
          end
        end
        pulse_chk(e0, e1);
        if (y == 0) chk("R7 block high", rd_block, 1);
        @(negedge clk);
      end
      pix_valid = 1'b0;
    end
    for (int w = 0; w < NW; w++) prev_sum[w] = cur_sum[w];
  endtask

  initial begin
    int lim;
    lim = 0;
    while (!done && lim < 150000) begin
      @(posedge clk);
      lim++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", lim, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      hl[w] = 0; hh[w] = 0; vl[w] = 0; vh[w] = 0; prev_sum[w] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk("R1 rd_block", rd_block, 0);
    chk("R1 pulse", win_pulse, 0);
    read_all("R1 held zero");
    rst_n = 1'b1;
    @(negedge clk);

    // field A: edges, single pixel, empty, overlap, beyond frame
    set_win(0, 0, FW-1, 0, FH-1);
    set_win(1, 5, 5, 5, 5);
    set_win(2, 10, 9, 3, 8);            // R3 empty
    set_win(3, FW-5, FW-1, FH-4, FH-1);
    set_win(4, 0, 10, 0, 3);            // R4 overlap with 0
    set_win(5, FW-2, 1023, FH-2, 1023);
    set_masks(6'b001010, 6'b010000);
    run_field(0, 1'b0);

    // field B: strobes carry samples that must be dropped
    set_win(0, 0, 0, 0, FH-1);
    set_win(1, 0, FW-1, 0, 0);
    set_win(2, 3, 30, 2, 2);
    set_win(3, 12, 12, 0, FH-1);
    set_win(4, 1, 38, 1, 22);
    set_win(5, 20, 25, 10, 15);
    set_masks(6'b100001, 6'b011110);
    run_field(1, 1'b1);

    // field C: full-scale samples
    set_masks(6'b111111, 6'b000000);
    run_field(2, 1'b1);

    // swept placements
    for (int k = 3; k < 8; k++) begin
      for (int w = 0; w < NW; w++) begin
        int a, c;
        a = (w*5 + k*3) % FW;
        c = (w*3 + k*2) % FH;
        set_win(w, a, a + (w + k) % 9, c, c + (w*k) % 7);
      end
      set_masks((k*11) & 63, (k*5 + 1) & 63);
      run_field(k, k[0]);
    end

    // one more field to read back the last totals
    run_field(0, 1'b0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule